// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Flags

This block receives asynchronous serial frames on a single line. The line is sampled on a baud tick that runs at sixteen times the bit rate. A frame has one start bit, eight or nine data bits sent least significant bit first, an optional parity bit and one stop bit. Each bit is decided by a majority vote of three samples taken near its centre. A finished frame is moved into a receive data register, and a set of sticky status flags records what happened on the line.

Software reads the data register and then pulses a read strobe, which empties the register. It clears individual flags by pulsing a clear mask. If a frame finishes while the previous byte is still unread, the receiver records an overrun, keeps the old byte, and discards the new one and every later one until the overrun flag is cleared. An idle-line detector watches for one whole frame time of ones. It ends the receiver-active indication and raises an idle flag. That flag is re-armed only by a fresh transfer into the data register, and a wake-up input can hold it off.

Top module: `uart_rx_status`

## Requirements
- R1: Each bit period is 16 ticks. Bit values are the majority of the samples at tick 7, 8 and 9 of the bit, counted from the tick that detects the start. A start bit whose majority is 1 is rejected, no frame is delivered, and the receiver returns to hunting for a start bit.
- R2: The noise flag is set when the three samples disagree on an accepted start bit, a data bit, the parity bit or the stop bit. A short low pulse on an idle line that causes a rejected start never sets it.
- R3: The noise, framing and parity flags change only on the cycle in which receive-full rises at the end of a frame. A noisy bit stays invisible until that cycle.
- R4: A stop bit that votes 0 sets the framing flag. A break (all bits 0, stop included) is delivered as data 0 with both receive-full and framing set.
- R5: A frame that completes while receive-full is set raises the overrun flag. The earlier data stays in the register, and the error flags of the lost frame are not recorded.
- R6: While the overrun flag is set, no frame is transferred and receive-full cannot rise, even after a read. This lasts until the overrun flag is cleared.
- R7: Receiver-active rises when a low level is seen while hunting, including a low level that turns out to be a rejected start. It falls when an idle line is detected.
- R8: The idle line is detected after (frame bits × 16) consecutive high ticks. With idle select 0, counting runs through the frame, so it can begin right after the start bit. With idle select 1, counting begins only when the stop bit has been voted.
- R9: The idle flag sets only if receive-full has risen since reset or since the flag last set. Clearing the flag, or reading data, does not re-arm it.
- R10: While the wake-up input is high, idle detection does not set the idle flag.
- R11: In 9-bit mode the ninth data bit is placed in data bit 8. In 8-bit mode data bit 8 reads 0.
- R12: When parity is enabled, it is computed over all data bits. Odd-select 0 expects an even count of ones across data and parity, and odd-select 1 expects an odd count. A mismatch sets the parity flag.
- R13: After reset all flags and the data register are 0. The read strobe clears receive-full. Clear mask bit 0 clears idle, bit 1 clears overrun, bit 2 clears noise, bit 3 clears framing and bit 4 clears parity. A clear affects only its own flag, and a flag being set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversample tick, 16 per bit |
| rxd_i | input | 1 | Serial line, idle high |
| nine_bit_i | input | 1 | 1 selects nine data bits |
| par_en_i | input | 1 | 1 adds a parity bit |
| par_odd_i | input | 1 | Parity sense, 1 is odd |
| idle_sel_i | input | 1 | Idle count start, 0 after start bit, 1 after stop bit |
| wake_i | input | 1 | Wake-up gate, 1 holds off the idle flag |
| rd_i | input | 1 | Read strobe, clears receive-full |
| clr_i | input | 5 | Flag clear mask |
| data_o | output | 9 | Receive data register |
| full_o | output | 1 | Receive-full flag |
| active_o | output | 1 | Receiver-active flag |
| idle_o | output | 1 | Idle-line flag |
| ovr_o | output | 1 | Overrun flag |
| noise_o | output | 1 | Noise flag |
| frame_o | output | 1 | Framing flag |
| par_o | output | 1 | Parity flag |

## Verification
The assertions check, on every cycle, the relations between flags. Error flags rise only together with receive-full. Overrun rises only while data is waiting, the data register holds steady during overrun, and receive-full cannot rise while overrun is set. The idle flag respects the wake-up gate and clears receiver-active, and bit 8 is 0 after an 8-bit frame. Only the bench scenarios can show that the vote lands on the right samples, that the parity sense and the data values are correct across full sweeps of byte values, that the two idle count types differ in timing, and that the idle flag is re-armed only by a new transfer.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic noise;
    logic framing;
    logic parity;
  } rx_err_t;

  localparam int CLR_IDLE  = 0;
  localparam int CLR_OVR   = 1;
  localparam int CLR_NOISE = 2;
  localparam int CLR_FRAME = 3;
  localparam int CLR_PAR   = 4;
  localparam int CLR_W     = 5;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_voter.sv
module uart_rx_voter #(
  parameter int OVS = 16,
  localparam int PW = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] ph,
  input  logic          rx,
  output logic          maj,
  output logic          dis
);
  localparam int MID = OVS / 2;
  localparam int V0  = MID - 1;

  logic s0_q, s0_d, s1_q, s1_d;

  always_comb begin
    s0_d = s0_q;
    s1_d = s1_q;
    if (en && ph == PW'(V0))  s0_d = rx;
    if (en && ph == PW'(MID)) s1_d = rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b1;
      s1_q <= 1'b1;
    end else begin
      s0_q <= s0_d;
      s1_q <= s1_d;
    end
  end

  // third vote is the live sample
  assign maj = (s0_q & s1_q) | (s0_q & rx) | (s1_q & rx);
  assign dis = !((s0_q == s1_q) && (s1_q == rx));
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  input  logic          hold,
  input  logic [CW-1:0] target,
  output logic          det
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    det   = 1'b0;
    if (tick) begin
      if (!rx || hold) begin
        cnt_d = '0;
      end else if (cnt_q < target) begin
        cnt_d = cnt_q + CW'(1);
        det   = (cnt_q + CW'(1)) == target;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  input  logic          nine,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          start_p,
  output logic          done_p,
  output logic          in_frame,
  output logic [DW-1:0] dout,
  output rx_err_t       err
);
  localparam int PW  = $clog2(OVS);
  localparam int BW  = $clog2(DW);
  localparam int MID = OVS / 2;
  localparam int V2  = MID + 1;

  rx_state_e     st_q, st_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [BW-1:0] bidx_q, bidx_d, last;
  logic [DW-1:0] sh_q, sh_d, dout_d;
  logic          nacc_q, nacc_d, pbit_q, pbit_d, done_d;
  rx_err_t       err_d;
  logic          maj, dis;

  uart_rx_voter #(.OVS(OVS)) u_vote (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (tick && st_q != ST_HUNT),
    .ph   (ph_q),
    .rx   (rx),
    .maj  (maj),
    .dis  (dis)
  );

  assign last     = nine ? BW'(DW - 1) : BW'(DW - 2);
  assign start_p  = tick && (st_q == ST_HUNT) && !rx;
  assign in_frame = st_q != ST_HUNT;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    bidx_d = bidx_q;
    sh_d   = sh_q;
    nacc_d = nacc_q;
    pbit_d = pbit_q;
    done_d = 1'b0;
    dout_d = dout;
    err_d  = err;
    if (tick) begin
      if (st_q == ST_HUNT) begin
        if (!rx) begin
          st_d   = ST_START;
          ph_d   = PW'(1);
          sh_d   = '0;
          nacc_d = 1'b0;
        end
      end else begin
        ph_d = ph_q + 1'b1;
        if (ph_q == PW'(V2)) begin
          case (st_q)
            ST_START: begin
              if (maj) st_d = ST_HUNT;     // false start
              else     nacc_d = dis;
            end
            ST_DATA: begin
              sh_d[bidx_q] = maj;
              nacc_d       = nacc_q | dis;
            end
            ST_PAR: begin
              pbit_d = maj;
              nacc_d = nacc_q | dis;
            end
            ST_STOP: begin
              done_d        = 1'b1;
              dout_d        = sh_q;
              err_d.noise   = nacc_q | dis;
              err_d.framing = !maj;
              err_d.parity  = par_en & ((^sh_q) ^ pbit_q ^ par_odd);
              st_d          = ST_HUNT;
            end
            default: ;
          endcase
        end
        if (ph_q == PW'(OVS - 1)) begin
          case (st_q)
            ST_START: begin
              st_d   = ST_DATA;
              bidx_d = '0;
            end
            ST_DATA: begin
              if (bidx_q == last) st_d = par_en ? ST_PAR : ST_STOP;
              else                bidx_d = bidx_q + 1'b1;
            end
            ST_PAR:  st_d = ST_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      ph_q   <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      nacc_q <= 1'b0;
      pbit_q <= 1'b0;
      done_p <= 1'b0;
      dout   <= '0;
      err    <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      bidx_q <= bidx_d;
      sh_q   <= sh_d;
      nacc_q <= nacc_d;
      pbit_q <= pbit_d;
      done_p <= done_d;
      dout   <= dout_d;
      err    <= err_d;
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int DW   = 9,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              nine_bit_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              idle_sel_i,
  input  logic              wake_i,
  input  logic              rd_i,
  input  logic [CLR_W-1:0]  clr_i,
  output logic [DW-1:0]     data_o,
  output logic              full_o,
  output logic              active_o,
  output logic              idle_o,
  output logic              ovr_o,
  output logic              noise_o,
  output logic              frame_o,
  output logic              par_o
);
  localparam int CW = $clog2(OVS * (DW + 3) + 1);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  logic          rx_s, start_p, done_p, in_frame, idle_det;
  logic [DW-1:0] fr_data;
  rx_err_t       fr_err;
  logic [CW-1:0] target;

  uart_rx_sync #(.STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .d    (rxd_i),
    .q    (rx_s)
  );

  uart_rx_frame #(.OVS(OVS), .DW(DW)) u_frame (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (tick_i),
    .rx      (rx_s),
    .nine    (nine_bit_i),
    .par_en  (par_en_i),
    .par_odd (par_odd_i),
    .start_p (start_p),
    .done_p  (done_p),
    .in_frame(in_frame),
    .dout    (fr_data),
    .err     (fr_err)
  );

  always_comb
    target = CW'((DW + 1 + (nine_bit_i ? 1 : 0) + (par_en_i ? 1 : 0)) * OVS);

  uart_rx_idle #(.CW(CW)) u_idle (
    .clk   (clk),
    .rst_n (rst_core_n),
    .tick  (tick_i),
    .rx    (rx_s),
    .hold  (idle_sel_i && in_frame),
    .target(target),
    .det   (idle_det)
  );

  // status registers
  logic [DW-1:0] data_q, data_d;
  logic full_q, full_d, ovr_q, ovr_d, noise_q, noise_d, frm_q, frm_d;
  logic par_q, par_d, idle_q, idle_d, act_q, act_d, arm_q, arm_d;
  logic xfer, ovr_set, idle_set;

  assign xfer     = done_p && !ovr_q && !full_q;
  assign ovr_set  = done_p && !ovr_q && full_q;
  assign idle_set = idle_det && arm_q && !wake_i;

  always_comb begin
    data_d  = xfer ? fr_data : data_q;
    full_d  = (full_q && !rd_i) || xfer;
    ovr_d   = (ovr_q && !clr_i[CLR_OVR]) || ovr_set;
    noise_d = (noise_q && !clr_i[CLR_NOISE]) || (xfer && fr_err.noise);
    frm_d   = (frm_q && !clr_i[CLR_FRAME]) || (xfer && fr_err.framing);
    par_d   = (par_q && !clr_i[CLR_PAR]) || (xfer && fr_err.parity);
    idle_d  = (idle_q && !clr_i[CLR_IDLE]) || idle_set;
    arm_d   = xfer || (arm_q && !idle_set);
    act_d   = start_p || (act_q && !idle_det);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      noise_q <= 1'b0;
      frm_q   <= 1'b0;
      par_q   <= 1'b0;
      idle_q  <= 1'b0;
      arm_q   <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      data_q  <= data_d;
      full_q  <= full_d;
      ovr_q   <= ovr_d;
      noise_q <= noise_d;
      frm_q   <= frm_d;
      par_q   <= par_d;
      idle_q  <= idle_d;
      arm_q   <= arm_d;
      act_q   <= act_d;
    end
  end

  assign data_o   = data_q;
  assign full_o   = full_q;
  assign active_o = act_q;
  assign idle_o   = idle_q;
  assign ovr_o    = ovr_q;
  assign noise_o  = noise_q;
  assign frame_o  = frm_q;
  assign par_o    = par_q;
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wake_i,
  input logic          nine_bit_i,
  input logic [DW-1:0] data_o,
  input logic          full_o,
  input logic          active_o,
  input logic          idle_o,
  input logic          ovr_o,
  input logic          noise_o,
  input logic          frame_o,
  input logic          par_o
);
  a_r3_noise_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noise_o) |-> $rose(full_o));
  a_r3_frame_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> $rose(full_o));
  a_r3_par_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_o) |-> $rose(full_o));
  a_r5_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> full_o);
  a_r5_ovr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && $past(ovr_o)) |-> $stable(data_o));
  a_r6_no_fill_in_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_o) |-> !$past(ovr_o));
  a_r7_idle_ends_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> !active_o);
  a_r10_wake_blocks_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> !$past(wake_i));
  a_r11_top_bit_8bit: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(full_o) && !$past(nine_bit_i)) |-> !data_o[DW-1]);
endmodule

bind uart_rx_status uart_rx_status_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wake_i    (wake_i),
  .nine_bit_i(nine_bit_i),
  .data_o    (data_o),
  .full_o    (full_o),
  .active_o  (active_o),
  .idle_o    (idle_o),
  .ovr_o     (ovr_o),
  .noise_o   (noise_o),
  .frame_o   (frame_o),
  .par_o     (par_o)
);

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
  localparam int OVS = 16;
  localparam int DW  = 9;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rxd = 1'b1;
  logic nine = 1'b0, pen = 1'b0, podd = 1'b0, sel = 1'b0, wake = 1'b0, rd = 1'b0;
  logic [4:0] clr = 5'b0;
  logic [DW-1:0] data_o;
  logic full_o, active_o, idle_o, ovr_o, noise_o, frame_o, par_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  uart_rx_status #(.OVS(OVS), .DW(DW), .SYNC(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd),
    .nine_bit_i(nine), .par_en_i(pen), .par_odd_i(podd),
    .idle_sel_i(sel), .wake_i(wake), .rd_i(rd), .clr_i(clr),
    .data_o(data_o), .full_o(full_o), .active_o(active_o), .idle_o(idle_o),
    .ovr_o(ovr_o), .noise_o(noise_o), .frame_o(frame_o), .par_o(par_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse_clr(input logic [4:0] m);
    @(negedge clk); clr = m;
    @(negedge clk); clr = 5'b0;
  endtask

  // one frame; gl = bit index whose middle sample is inverted (-1 for none)
  task automatic send(input logic [8:0] d, input bit perr, input bit stopv,
                      input int gl, input bit midchk);
    logic [11:0] b;
    int nd, nb;
    nd = nine ? 9 : 8;
    b = '0;
    for (int i = 0; i < nd; i++) b[1+i] = d[i];
    nb = 1 + nd;
    if (pen) begin
      b[nb] = (^(d & (nine ? 9'h1FF : 9'h0FF))) ^ podd ^ perr;
      nb++;
    end
    b[nb] = stopv;
    nb++;
    for (int j = 0; j < nb; j++) begin
      for (int k = 0; k < OVS; k++) begin
        @(negedge clk);
        rxd = (j == gl && k == OVS / 2) ? ~b[j] : b[j];
        if (midchk && j == nb - 1 && k == 0) chk("R3 noise hidden before frame end", noise_o, 0);
      end
    end
    @(negedge clk); rxd = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R13 reset data", data_o, 0);
    chk("R13 reset flags", {full_o, active_o, idle_o, ovr_o, noise_o, frame_o, par_o}, 0);

    // R1 / R11: every byte in 8-bit mode without parity
    for (int v = 0; v < 256; v++) begin
      send(9'(v), 0, 1, -1, 0);
      chk("R1 data", data_o, v);
      chk("R1 full and clean flags", {full_o, ovr_o, noise_o, frame_o, par_o}, 5'b10000);
      pulse_rd();
      if (v == 0) chk("R13 read clears full", full_o, 0);
    end

    // R12: every byte with parity, alternating sense, some bad
    pen = 1'b1;
    for (int v = 0; v < 256; v++) begin
      podd = v[0];
      send(9'(v), (v % 3) == 0, 1, -1, 0);
      chk("R12 parity flag", par_o, ((v % 3) == 0) ? 1 : 0);
      chk("R12 data", data_o, v);
      pulse_clr(5'b10000);
      pulse_rd();
    end

    // R11: nine data bits
    pen = 1'b0; nine = 1'b1;
    for (int i = 0; i < 64; i++) begin
      send(9'((i * 83 + 5) % 512), 0, 1, -1, 0);
      chk("R11 nine-bit data", data_o, (i * 83 + 5) % 512);
      pulse_rd();
    end
    pen = 1'b1; podd = 1'b0;
    send(9'h100, 0, 1, -1, 0);
    chk("R12 parity covers bit 8", {par_o, data_o}, 10'h100);
    pulse_rd();
    pen = 1'b0; nine = 1'b0;
    send(9'h0FF, 0, 1, -1, 0);
    chk("R11 bit 8 zero in 8-bit mode", data_o, 9'h0FF);
    pulse_rd();

    // R2: noise on start, data and stop bits
    send(9'h5A, 0, 1, 0, 0);
    chk("R2 noise on start", {noise_o, data_o}, 10'h25A);
    pulse_clr(5'b00100); pulse_rd();
    send(9'h3C, 0, 1, 4, 1);
    chk("R2 noise on data, majority kept", {noise_o, data_o}, 10'h23C);
    pulse_clr(5'b00100); pulse_rd();
    send(9'hC3, 0, 1, 9, 0);
    chk("R2 noise on stop", {noise_o, frame_o, data_o}, 11'h4C3);
    pulse_clr(5'b00100); pulse_rd();

    // R1 / R2 / R7: one-clock low glitch is a rejected start
    @(negedge clk); rxd = 1'b0;
    @(negedge clk); rxd = 1'b1;
    wait_clk(40);
    chk("R2 no noise from rejected start", noise_o, 0);
    chk("R1 rejected start delivers nothing", full_o, 0);
    chk("R7 active after low level", active_o, 1);
    wait_clk(200);
    chk("R7 active cleared by idle", active_o, 0);

    // R4 / R13: framing, selective clear, break
    send(9'hA5, 0, 0, 2, 0);
    chk("R4 framing with data", {frame_o, noise_o, data_o}, 11'h6A5);
    pulse_clr(5'b00100);
    chk("R13 clear touches only its flag", {frame_o, noise_o}, 2'b10);
    pulse_clr(5'b01000); pulse_rd();
    send(9'h000, 0, 0, -1, 0);
    chk("R4 break", {full_o, frame_o, data_o}, 11'h600);
    pulse_clr(5'b01000); pulse_rd();

    // R5 / R6: overrun
    pulse_clr(5'b11111);
    send(9'h11, 0, 1, -1, 0);
    send(9'h22, 0, 0, -1, 0);
    chk("R5 overrun keeps old data", {ovr_o, full_o, data_o}, 11'h611);
    chk("R5 lost frame error ignored", frame_o, 0);
    send(9'h33, 0, 1, -1, 0);
    chk("R6 still old data", data_o, 9'h11);
    pulse_rd();
    send(9'h44, 0, 1, -1, 0);
    chk("R6 no transfer while overrun", {ovr_o, full_o, data_o}, 11'h411);
    pulse_clr(5'b00010);
    send(9'h55, 0, 1, -1, 0);
    chk("R6 transfer resumes", {ovr_o, full_o, data_o}, 11'h255);
    pulse_rd();

    // R8 / R9: idle detection and re-arm
    pulse_clr(5'b11111);
    send(9'h12, 0, 1, -1, 0);
    wait_clk(200);
    chk("R8 idle after frame", {idle_o, active_o}, 2'b10);
    pulse_clr(5'b00001);
    wait_clk(200);
    chk("R9 no re-set without new data", idle_o, 0);
    pulse_rd();
    wait_clk(200);
    chk("R9 read does not re-arm", idle_o, 0);
    send(9'h34, 0, 1, -1, 0);
    wait_clk(200);
    chk("R9 re-armed by new data", idle_o, 1);
    pulse_clr(5'b00001); pulse_rd();

    // R10: wake-up gate
    wake = 1'b1;
    send(9'h56, 0, 1, -1, 0);
    wait_clk(200);
    chk("R10 wake holds idle flag off", {idle_o, active_o}, 2'b00);
    wake = 1'b0;
    pulse_rd(); pulse_clr(5'b11111);

    // R8: idle count start selection
    sel = 1'b0;
    send(9'hFF, 0, 1, -1, 0);
    wait_clk(20);
    chk("R8 select 0 counts from start bit", idle_o, 1);
    pulse_clr(5'b00001); pulse_rd();
    sel = 1'b1;
    send(9'hFF, 0, 1, -1, 0);
    wait_clk(20);
    chk("R8 select 1 not yet idle", idle_o, 0);
    wait_clk(200);
    chk("R8 select 1 idle after stop", idle_o, 1);
    sel = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule